// File: doc/BRIEF.md
# Late-Operation Prefix Adder

This combinational block adds two unsigned W-bit operands with a parallel prefix carry tree and folds two extra operations into the sum stage. After the tree has produced its group-generate and group-not-kill prefixes, a late carry is formed for every bit. That late carry can add one to the sum or drive a conditional inversion of the sum. As a result, one adder delivers A+B, A+B+inc and |A−B|, with no second adder and no output multiplexer between two adders.

A two-bit operation select chooses among the three functions. In absolute-difference mode the B operand is inverted ahead of the tree, so the raw sum is A−B−1. The raw carry-out then tells whether A is strictly greater than B. If it is, the late increment yields A−B. If it is not, every raw sum bit is inverted, which yields B−A. The block is used wherever a sum, a rounded sum or a magnitude of difference is needed from one datapath, such as motion-estimation cost units.

Top module: `lateop_adder`

## Requirements
- R1: With mode 0 (add), {co_o, sum_o} equals A+B computed at W+1 bits, and inc_i has no effect.
- R2: With mode 1 (late increment), {co_o, sum_o} equals A+B+inc_i computed at W+1 bits.
- R3: With mode 2 (absolute difference), sum_o equals A−B when A>B and B−A otherwise.
- R4: With mode 2, co_o is 1 exactly when A>B, and 0 otherwise.
- R5: With mode 2, inc_i has no effect on sum_o or co_o.
- R6: With mode 2 and A equal to B, sum_o is zero and co_o is 0.
- R7: Mode 3 behaves exactly like mode 0 (add, inc_i ignored).
- R8: With mode 1, inc_i=1 and A+B equal to 2^W−1, sum_o wraps to zero and co_o is 1.
- R9: The behaviour above holds for any width W of at least 2; it is exercised exhaustively at W=8 and by random vectors at W=16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First unsigned operand |
| b_i | input | W | Second unsigned operand |
| inc_i | input | 1 | Late increment request, used in mode 1 only |
| mode_i | input | 2 | Operation: 0 add, 1 add with increment, 2 absolute difference, 3 same as add |
| sum_o | output | W | Result |
| co_o | output | 1 | Carry-out, or in mode 2 the A>B flag |

## Verification
The bound checker compares the outputs against arithmetic references whenever an input changes. It covers the sum and carry for each mode, the A>B flag and the zero result for equal operands. Two properties can only be shown by the scenarios. One is that inc_i is ignored in add and difference modes, which needs paired stimulus with inc_i toggled. The other is that the function holds at more than one width, which needs the exhaustive 8-bit sweep next to the random 16-bit run. The carry wrap-around at an all-ones sum is hit by directed vectors.

// File: rtl/lateop_pkg.sv
package lateop_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_INC = 2'd1,
    OP_ABS = 2'd2,
    OP_ALT = 2'd3
  } op_e;
endpackage

// File: rtl/lateop_bitgen.sv
// Per-bit generate, propagate and not-kill terms; B is inverted for difference.
module lateop_bitgen
  import lateop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_b_i,
  output logic [W-1:0] g_o,
  output logic [W-1:0] p_o,
  output logic [W-1:0] nk_o
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = b_i ^ {W{inv_b_i}};
    g_o   = a_i & b_eff;
    p_o   = a_i ^ b_eff;
    nk_o  = a_i | b_eff;
  end
endmodule

// File: rtl/lateop_ks_tree.sv
// Log-depth prefix tree with unit lateral fan-out; outputs groups (i:0).
module lateop_ks_tree #(
  parameter int W = 16
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] nk_i,
  output logic [W-1:0] grp_g_o,
  output logic [W-1:0] grp_nk_o
);
  localparam int LV = $clog2(W);

  logic [W-1:0] gl [0:LV];
  logic [W-1:0] nl [0:LV];

  assign gl[0] = g_i;
  assign nl[0] = nk_i;

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int D = 1 << l;
    for (genvar i = 0; i < W; i++) begin : g_col
      if (i >= D) begin : g_cell
        assign gl[l+1][i] = gl[l][i] | (nl[l][i] & gl[l][i-D]);
        assign nl[l+1][i] = nl[l][i] & nl[l][i-D];
      end else begin : g_wire
        assign gl[l+1][i] = gl[l][i];
        assign nl[l+1][i] = nl[l][i];
      end
    end
  end

  assign grp_g_o  = gl[LV];
  assign grp_nk_o = nl[LV];
endmodule

// File: rtl/lateop_sumstage.sv
// Late carry formation, conditional inversion and carry-out selection.
module lateop_sumstage
  import lateop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] grp_g_i,
  input  logic [W-1:0] grp_nk_i,
  input  logic [1:0]   mode_i,
  input  logic         inc_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);
  logic [W-1:0] c_in;
  logic [W-1:0] nk_below;
  logic [W-1:0] late_c;
  logic         raw_co;
  logic         late_en;
  logic         flip;

  always_comb begin
    c_in     = {grp_g_i[W-2:0], 1'b0};
    nk_below = {grp_nk_i[W-2:0], 1'b1};
    raw_co   = grp_g_i[W-1];
    unique case (op_e'(mode_i))
      OP_INC:  late_en = inc_i;
      OP_ABS:  late_en = raw_co;
      default: late_en = 1'b0;
    endcase
    flip   = (op_e'(mode_i) == OP_ABS) & ~raw_co;
    late_c = c_in | ({W{late_en}} & nk_below);
    sum_o  = (p_i ^ late_c) ^ {W{flip}};
    if (op_e'(mode_i) == OP_INC) co_o = raw_co | (inc_i & grp_nk_i[W-1]);
    else                         co_o = raw_co;
  end
endmodule

// File: rtl/lateop_adder.sv
module lateop_adder
  import lateop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inc_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);
  logic [W-1:0] g_w, p_w, nk_w;
  logic [W-1:0] grp_g, grp_nk;
  logic         inv_b;

  assign inv_b = (op_e'(mode_i) == OP_ABS);

  lateop_bitgen #(.W(W)) u_bitgen (
    .a_i(a_i), .b_i(b_i), .inv_b_i(inv_b),
    .g_o(g_w), .p_o(p_w), .nk_o(nk_w)
  );

  lateop_ks_tree #(.W(W)) u_tree (
    .g_i(g_w), .nk_i(nk_w),
    .grp_g_o(grp_g), .grp_nk_o(grp_nk)
  );

  lateop_sumstage #(.W(W)) u_sum (
    .p_i(p_w), .grp_g_i(grp_g), .grp_nk_i(grp_nk),
    .mode_i(mode_i), .inc_i(inc_i),
    .sum_o(sum_o), .co_o(co_o)
  );
endmodule

// File: rtl/lateop_adder_chk.sv
module lateop_adder_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         inc_i,
  input logic [1:0]   mode_i,
  input logic [W-1:0] sum_o,
  input logic         co_o
);
  logic [W:0]   ref_add;
  logic [W:0]   ref_inc;
  logic [W-1:0] ref_abs;

  always_comb begin
    ref_add = {1'b0, a_i} + {1'b0, b_i};
    ref_inc = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, inc_i};
    ref_abs = (a_i > b_i) ? (a_i - b_i) : (b_i - a_i);
    if (mode_i == 2'd0 || mode_i == 2'd3) begin
      assert_add_result_R1: assert ({co_o, sum_o} == ref_add)
        else $error("add result mismatch");
    end
    if (mode_i == 2'd1) begin
      assert_inc_result_R2: assert ({co_o, sum_o} == ref_inc)
        else $error("increment result mismatch");
    end
    if (mode_i == 2'd2) begin
      assert_abs_result_R3: assert (sum_o == ref_abs)
        else $error("difference result mismatch");
      assert_abs_flag_R4: assert (co_o == (a_i > b_i))
        else $error("difference flag mismatch");
      if (a_i == b_i) begin
        assert_abs_equal_R6: assert (sum_o == '0 && !co_o)
          else $error("equal operands not zero");
      end
    end
  end
endmodule

bind lateop_adder lateop_adder_chk #(.W(W)) u_chk (
  .a_i(a_i), .b_i(b_i), .inc_i(inc_i), .mode_i(mode_i),
  .sum_o(sum_o), .co_o(co_o)
);

// File: tb/lateop_adder_test.sv
module lateop_adder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic clk;
  logic rst_n;
  int   n_total;
  int   n_bad;
  bit   finished;

  logic [15:0] a16, b16, s16;
  logic        inc16, co16;
  logic [1:0]  m16;
  logic [7:0]  a8, b8, s8;
  logic        inc8, co8;
  logic [1:0]  m8;

  lateop_adder #(.W(16)) uut (
    .a_i(a16), .b_i(b16), .inc_i(inc16), .mode_i(m16), .sum_o(s16), .co_o(co16)
  );

  lateop_adder #(.W(8)) uut8 (
    .a_i(a8), .b_i(b8), .inc_i(inc8), .mode_i(m8), .sum_o(s8), .co_o(co8)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [16:0] model(input logic [1:0] m, input logic [15:0] a,
                                        input logic [15:0] b, input logic inc, input int w);
    longint t;
    longint msk;
    msk = (longint'(1) << (w + 1)) - 1;
    if (m == 2'd2) begin
      if (a > b) t = (longint'(1) << w) | longint'(a - b);
      else       t = longint'(b - a);
    end else if (m == 2'd1) begin
      t = longint'(a) + longint'(b) + longint'(inc);
    end else begin
      t = longint'(a) + longint'(b);
    end
    return 17'(t & msk);
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'd0:    return "R1";
      2'd1:    return "R2";
      2'd2:    return "R3/R4";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run16(input string tag, input logic [1:0] m, input logic [15:0] a,
                       input logic [15:0] b, input logic inc);
    m16 = m; a16 = a; b16 = b; inc16 = inc;
    #1;
    check(tag, {co16, s16}, model(m, a, b, inc, 16));
  endtask

  task automatic run8(input string tag, input logic [1:0] m, input logic [7:0] a,
                      input logic [7:0] b, input logic inc);
    m8 = m; a8 = a; b8 = b; inc8 = inc;
    #1;
    check(tag, {8'd0, co8, s8}, model(m, {8'd0, a}, {8'd0, b}, inc, 8));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (cyc < WD_LIMIT) begin
      @(posedge clk);
      cyc++;
    end
    n_total++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
    finish_run();
  end

  initial begin : stim
    logic [15:0] ra, rb;
    logic        ri;
    logic [1:0]  rm;
    logic [16:0] keep;
    n_total = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0;
    a16 = '0; b16 = '0; inc16 = 1'b0; m16 = 2'd0;
    a8 = '0; b8 = '0; inc8 = 1'b0; m8 = 2'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Idle state: zero operands in add mode give zero.
    #1;
    check("R1 idle", {co16, s16}, 17'd0);

    // R8: all-ones sum plus increment wraps with carry.
    run16("R8", 2'd1, 16'hFFFF, 16'h0000, 1'b1);
    check("R8 zero", {1'b0, s16}, 17'd0);
    run16("R8", 2'd1, 16'h8000, 16'h7FFF, 1'b1);
    run8("R8", 2'd1, 8'hF0, 8'h0F, 1'b1);

    // R6: equal operands in difference mode.
    run16("R6", 2'd2, 16'h1234, 16'h1234, 1'b0);
    check("R6 zero", {co16, s16}, 17'd0);
    run16("R6", 2'd2, 16'hFFFF, 16'hFFFF, 1'b1);
    run16("R3", 2'd2, 16'h0000, 16'hFFFF, 1'b0);
    run16("R4", 2'd2, 16'hFFFF, 16'h0000, 1'b0);
    run16("R4", 2'd2, 16'h0001, 16'h0000, 1'b0);

    // R5: inc has no effect in difference mode.
    run16("R5", 2'd2, 16'h00A0, 16'h0300, 1'b0);
    keep = {co16, s16};
    run16("R5", 2'd2, 16'h00A0, 16'h0300, 1'b1);
    check("R5 same", {co16, s16}, keep);

    // R1 and R7: inc ignored in add and spare mode.
    run16("R1", 2'd0, 16'hFFFF, 16'h0001, 1'b1);
    run16("R7", 2'd3, 16'hFFFF, 16'h0001, 1'b1);
    run16("R7", 2'd3, 16'h7FFF, 16'h7FFF, 1'b0);

    // R9: exhaustive sweep at 8 bits.
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        run8("R9 R1", 2'd0, 8'(x), 8'(y), 1'(y));
        run8("R9 R2", 2'd1, 8'(x), 8'(y), 1'(x ^ y));
        run8("R9 R3", 2'd2, 8'(x), 8'(y), 1'(x));
      end
    end
    run8("R9 R7", 2'd3, 8'hFF, 8'hFF, 1'b1);

    // R9: random vectors at 16 bits.
    void'($urandom(32'd20240611));
    for (int k = 0; k < 20000; k++) begin
      ra = 16'($urandom);
      rb = (k % 16 == 0) ? ra : 16'($urandom);
      ri = 1'($urandom);
      rm = 2'($urandom);
      run16(tag_of(rm), rm, ra, rb, ri);
    end

    finish_run();
  end
endmodule